// File: doc/BRIEF.md
# PN23 Built-In Self-Test Generator and Checker

This block gives a serial link a self-test path that works on 8-bit characters ahead of line coding. The transmit half starts its test sequence automatically when `test_en` goes high. It first sends a fixed number of synchronization events made of control characters. It then sends an endless stream of characters from a 23-bit pseudo-noise generator whose polynomial is 1 + x^5 + x^23.

The receive half runs its own copy of the same generator and locks that copy onto the incoming stream. It loads its reference register straight from the received bits. It then asks for a run of consecutive matching characters before it declares lock. Once locked, the reference runs freely and every differing character adds one to a saturating 8-bit error count. While the test is active, the count and a 3-bit status code replace the normal receive outputs. When the test ends, those outputs carry received data again, and the checker has to synchronize afresh the next time the test is entered.

Top module: `pn_bist`

## Requirements
- R1: On the first clock edge with `test_en` high, the transmitter begins a sync phase. This phase lasts SYNC_EVENTS*SYNC_LEN characters (8 by default), and each one is 8'hBC with `tx_k`=1. After the sync phase, every character has `tx_k`=0.
- R2: A pattern character comes from 8 generator steps. Each step computes a new bit = s[22] xor s[4] and shifts it in at s[0]. The first new bit of a character is bit 7. The generator restarts from SEED (default 23'h000001) whenever the test is inactive.
- R3: Status appears on {`rd_err`,`rd_k`,`rd_idle`} during the test. The code 3'b001 means unlocked, 3'b000 means locked with no errors, and 3'b100 means locked with errors. The checker ignores characters with `rx_k`=1. It loads 3 data characters into its 23-bit reference and then needs LOCK_CNT (default 4) consecutive matches before it locks.
- R4: After lock, each received character that differs from the reference character adds exactly one to the error count. The reference keeps running on its own after a single bad character.
- R5: The error count saturates at 8'hFF and never wraps.
- R6: During the test, `rd_data` shows the error count. The count is zero from the first cycle of each test entry.
- R7: With `test_en` low, `rd_data` equals `rx_data` and the status outputs are {0,`rx_k`,0}. Leaving the test drops lock, so a new entry starts as unlocked.
- R8: If a load would leave the reference all zeros, the load restarts. A stream of all-zero data characters therefore never produces lock.
- R9: With `test_en` low, the transmitter outputs 8'h00 with `tx_k`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| test_en | input | 1 | Self-test mode enable |
| tx_data | output | 8 | Transmit character |
| tx_k | output | 1 | Transmit character is a control character |
| rx_data | input | 8 | Received character |
| rx_k | input | 1 | Received character is a control character |
| rd_data | output | 8 | Received data, or the error count during the test |
| rd_err | output | 1 | Error flag, or status bit 2 during the test |
| rd_k | output | 1 | Control flag, or status bit 1 during the test |
| rd_idle | output | 1 | Idle flag, or status bit 0 during the test |

## Verification
The bench loops the transmitter back to the receiver. A clean loopback checks the exact sync length, the first pattern bytes against an independent model, and the cycle at which lock is declared. A single flipped character separates correct per-character counting from a checker that loses its place. A long burst of flipped characters separates saturation from wrap-around. A forced all-zero stream shows that the degenerate seed can never produce lock. An exit followed by re-entry shows that the count clears and that the checker synchronizes again.

// File: rtl/pn_bist_pkg.sv
package pn_bist_pkg;
    localparam int PN_W   = 23;
    localparam int CHAR_W = 8;
    localparam logic [CHAR_W-1:0] SYNC_CHAR = 8'hBC;

    typedef logic [PN_W-1:0]   pn_state_t;
    typedef logic [CHAR_W-1:0] char_t;

    typedef struct packed {
        pn_state_t nxt;
        char_t     ch;
    } pn_step_t;

    typedef enum logic [1:0] {TX_IDLE, TX_SYNC, TX_PN} tx_phase_e;
    typedef enum logic [1:0] {CK_OFF, CK_LOAD, CK_VERIFY, CK_LOCK} ck_state_e;

    typedef struct packed {
        logic err;
        logic k;
        logic idle;
    } rx_flags_t;

    // Eight steps of 1 + x^5 + x^23, first new bit lands in bit 7.
    function automatic pn_step_t pn_advance(pn_state_t s);
        pn_step_t r;
        logic     fb;
        r.nxt = s;
        r.ch  = '0;
        for (int i = CHAR_W - 1; i >= 0; i--) begin
            fb    = r.nxt[PN_W-1] ^ r.nxt[4];
            r.nxt = {r.nxt[PN_W-2:0], fb};
            r.ch[i] = fb;
        end
        return r;
    endfunction
endpackage

// File: rtl/pn_tx_gen.sv
module pn_tx_gen
    import pn_bist_pkg::*;
#(
    parameter int        SYNC_TOTAL = 8,
    parameter pn_state_t SEED       = 23'h000001
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  test_en,
    output char_t tx_data,
    output logic  tx_k
);
    localparam int CW = $clog2(SYNC_TOTAL + 1);

    tx_phase_e phase;
    logic [CW-1:0] cnt;
    pn_state_t lfsr;
    pn_step_t  stp;

    always_ff @(posedge clk) begin
        if (rst || !test_en) begin
            phase <= TX_IDLE;
            cnt   <= '0;
            lfsr  <= SEED;
        end else begin
            case (phase)
                TX_IDLE: begin
                    phase <= TX_SYNC;
                    cnt   <= '0;
                end
                TX_SYNC: begin
                    if (cnt == CW'(SYNC_TOTAL - 1)) phase <= TX_PN;
                    else cnt <= cnt + 1'b1;
                end
                default: lfsr <= stp.nxt;
            endcase
        end
    end

    always_comb begin
        stp = pn_advance(lfsr);
        case (phase)
            TX_SYNC: begin tx_data = SYNC_CHAR; tx_k = 1'b1; end
            TX_PN:   begin tx_data = stp.ch;    tx_k = 1'b0; end
            default: begin tx_data = '0;        tx_k = 1'b0; end
        endcase
    end

    // R1: pattern starts only after the full sync count
    p_sync_len_r1: assert property (@(posedge clk) disable iff (rst)
        (phase == TX_PN && $past(phase) == TX_SYNC) |-> $past(cnt) == CW'(SYNC_TOTAL - 1));

    // R2: generator never holds the all-zero state
    p_seed_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
        lfsr != '0);
endmodule

// File: rtl/pn_rx_check.sv
module pn_rx_check
    import pn_bist_pkg::*;
#(
    parameter int LOCK_CNT = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  test_en,
    input  char_t rx_data,
    input  logic  rx_k,
    output char_t err_cnt,
    output logic  locked
);
    localparam int MW = $clog2(LOCK_CNT + 1);

    ck_state_e st;
    pn_state_t ref_q;
    logic [1:0] ld_cnt;
    logic [MW-1:0] match_cnt;
    pn_step_t  exp_s;
    pn_state_t loaded;
    logic      hit;

    always_comb begin
        exp_s  = pn_advance(ref_q);
        loaded = {ref_q[PN_W-CHAR_W-1:0], rx_data};
        hit    = !rx_k && (rx_data == exp_s.ch);
    end

    always_ff @(posedge clk) begin
        if (rst || !test_en) begin
            st        <= CK_OFF;
            ref_q     <= '0;
            ld_cnt    <= '0;
            match_cnt <= '0;
            err_cnt   <= '0;
        end else begin
            case (st)
                CK_OFF: begin
                    st     <= CK_LOAD;
                    ld_cnt <= '0;
                end
                CK_LOAD: if (!rx_k) begin
                    ref_q <= loaded;
                    if (ld_cnt == 2'd2) begin
                        ld_cnt <= '0;
                        if (loaded != '0) begin
                            st        <= CK_VERIFY;
                            match_cnt <= '0;
                        end
                    end else begin
                        ld_cnt <= ld_cnt + 1'b1;
                    end
                end
                CK_VERIFY: begin
                    if (hit) begin
                        ref_q <= exp_s.nxt;
                        if (match_cnt == MW'(LOCK_CNT - 1)) st <= CK_LOCK;
                        else match_cnt <= match_cnt + 1'b1;
                    end else begin
                        st     <= CK_LOAD;
                        ld_cnt <= '0;
                    end
                end
                default: begin
                    ref_q <= exp_s.nxt;
                    if (!hit && err_cnt != 8'hFF) err_cnt <= err_cnt + 1'b1;
                end
            endcase
        end
    end

    assign locked = (st == CK_LOCK);

    // R5: saturated count stays put while the test runs
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        (err_cnt == 8'hFF && test_en) |=> (err_cnt == 8'hFF || !test_en));

    // R4: count moves by at most one per character
    p_step_one_r4: assert property (@(posedge clk) disable iff (rst)
        (test_en && $past(test_en)) |-> (err_cnt == $past(err_cnt) || err_cnt == $past(err_cnt) + 8'd1));

    // R3: lock is reached only through verification
    p_lock_path_r3: assert property (@(posedge clk) disable iff (rst)
        (st == CK_LOCK) |-> ($past(st) == CK_LOCK || $past(st) == CK_VERIFY));

    // R8: reference is never all zeros once past loading
    p_ref_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
        (st == CK_VERIFY || st == CK_LOCK) |-> ref_q != '0);

    // R6: count is zero after any inactive cycle
    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(test_en) |-> err_cnt == '0);
endmodule

// File: rtl/pn_bist.sv
module pn_bist
    import pn_bist_pkg::*;
#(
    parameter int          SYNC_LEN    = 4,
    parameter int          SYNC_EVENTS = 2,
    parameter int          LOCK_CNT    = 4,
    parameter logic [22:0] SEED        = 23'h000001
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       test_en,
    output logic [7:0] tx_data,
    output logic       tx_k,
    input  logic [7:0] rx_data,
    input  logic       rx_k,
    output logic [7:0] rd_data,
    output logic       rd_err,
    output logic       rd_k,
    output logic       rd_idle
);
    localparam int SYNC_TOTAL = SYNC_LEN * SYNC_EVENTS;

    char_t     cnt;
    logic      locked;
    rx_flags_t flags;

    pn_tx_gen #(.SYNC_TOTAL(SYNC_TOTAL), .SEED(SEED)) u_tx (
        .clk(clk), .rst(rst), .test_en(test_en),
        .tx_data(tx_data), .tx_k(tx_k)
    );

    pn_rx_check #(.LOCK_CNT(LOCK_CNT)) u_rx (
        .clk(clk), .rst(rst), .test_en(test_en),
        .rx_data(rx_data), .rx_k(rx_k),
        .err_cnt(cnt), .locked(locked)
    );

    always_comb begin
        if (test_en) begin
            rd_data    = cnt;
            flags.err  = locked && (cnt != '0);
            flags.k    = 1'b0;
            flags.idle = !locked;
        end else begin
            rd_data    = rx_data;
            flags.err  = 1'b0;
            flags.k    = rx_k;
            flags.idle = 1'b0;
        end
    end

    assign {rd_err, rd_k, rd_idle} = flags;

    // R3: only one status bit may be set during the test
    p_status_code_r3: assert property (@(posedge clk) disable iff (rst)
        test_en |-> $onehot0({rd_err, rd_k, rd_idle}));
endmodule

// File: tb/test_pn_bist.sv
module test_pn_bist;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic test_en = 1'b0;
    logic [7:0] tx_data, rx_data, rd_data;
    logic tx_k, rx_k, rd_err, rd_k, rd_idle;
    logic use_force = 1'b0;
    logic [7:0] force_data = '0;
    logic force_k = 1'b0;
    logic [7:0] flip = '0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign rx_data = use_force ? force_data : (tx_data ^ flip);
    assign rx_k    = use_force ? force_k : tx_k;

    pn_bist i_pn_bist (
        .clk(clk), .rst(rst), .test_en(test_en),
        .tx_data(tx_data), .tx_k(tx_k),
        .rx_data(rx_data), .rx_k(rx_k),
        .rd_data(rd_data), .rd_err(rd_err), .rd_k(rd_k), .rd_idle(rd_idle)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_byte(ref logic [22:0] s);
        logic [7:0] b;
        logic nb;
        b = '0;
        for (int i = 7; i >= 0; i--) begin
            nb   = s[22] ^ s[4];
            s    = {s[21:0], nb};
            b[i] = nb;
        end
        return b;
    endfunction

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        check("R9 idle tx data", {8'h00, tx_data}, 16'h0000);
        check("R9 idle tx k", {15'h0, tx_k}, 16'h0000);
    endtask

    task automatic t_entry_and_lock();
        logic [22:0] m;
        m = 23'h000001;
        @(negedge clk) test_en = 1'b1;
        @(posedge clk);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (i < 8) begin
                check("R1 sync char", {7'h0, tx_k, tx_data}, {8'h01, 8'hBC});
            end else begin
                check("R2 pattern char", {7'h0, tx_k, tx_data}, {8'h00, model_byte(m)});
            end
            if (i == 0) check("R6 zero count at entry", {8'h0, rd_data}, 16'h0000);
            if (i == 14) check("R3 unlocked before last match", {13'h0, rd_err, rd_k, rd_idle}, 16'h0001);
            if (i == 15) check("R3 locked after matches", {13'h0, rd_err, rd_k, rd_idle}, 16'h0000);
            @(posedge clk);
        end
        @(negedge clk);
        check("R6 clean count", {8'h0, rd_data}, 16'h0000);
    endtask

    task automatic t_single_error();
        @(negedge clk) flip = 8'h01;
        @(negedge clk) flip = 8'h00;
        check("R4 one error counted", {8'h0, rd_data}, 16'h0001);
        check("R3 locked with errors", {13'h0, rd_err, rd_k, rd_idle}, 16'h0004);
        repeat (6) @(negedge clk);
        check("R4 reference keeps running", {8'h0, rd_data}, 16'h0001);
    endtask

    task automatic t_saturate();
        @(negedge clk) flip = 8'hFF;
        repeat (300) @(negedge clk);
        check("R5 saturated", {8'h0, rd_data}, 16'h00FF);
        repeat (5) @(negedge clk);
        check("R5 no wrap", {8'h0, rd_data}, 16'h00FF);
        flip = 8'h00;
    endtask

    task automatic t_exit_reenter();
        @(negedge clk) begin
            test_en = 1'b0;
            use_force = 1'b1;
            force_data = 8'h5A;
            force_k = 1'b1;
        end
        @(negedge clk);
        check("R7 passthrough data", {8'h0, rd_data}, 16'h005A);
        check("R7 passthrough flags", {13'h0, rd_err, rd_k, rd_idle}, 16'h0002);
        check("R9 tx idle after exit", {7'h0, tx_k, tx_data}, 16'h0000);
        use_force = 1'b0;
        test_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R6 count cleared on reentry", {8'h0, rd_data}, 16'h0000);
        check("R7 unlocked on reentry", {13'h0, rd_err, rd_k, rd_idle}, 16'h0001);
        repeat (25) @(negedge clk);
        check("R3 relocked", {13'h0, rd_err, rd_k, rd_idle}, 16'h0000);
    endtask

    task automatic t_zero_stream();
        @(negedge clk) test_en = 1'b0;
        @(negedge clk) begin
            use_force = 1'b1;
            force_data = 8'h00;
            force_k = 1'b0;
            test_en = 1'b1;
        end
        repeat (40) @(negedge clk);
        check("R8 no lock on zeros", {13'h0, rd_err, rd_k, rd_idle}, 16'h0001);
        use_force = 1'b0;
        repeat (30) @(negedge clk);
        check("R8 locks after real stream", {13'h0, rd_err, rd_k, rd_idle}, 16'h0000);
        check("R6 no errors before lock", {8'h0, rd_data}, 16'h0000);
    endtask

    initial begin
        t_reset();
        t_entry_and_lock();
        t_single_error();
        t_saturate();
        t_exit_reenter();
        t_zero_stream();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule